// File: doc/BRIEF.md
# Event State Page Controller

This block decodes accesses to a window of event-state pages. Each queue owns two adjacent pages. The even page controls the queue's notification P/Q bit pair, and the odd page controls its escalation P/Q bit pair. The page address gives the queue index and the page parity. The low 4 KB offset inside the page selects the operation. For loads, the operation is get, set or end-of-interrupt. For stores, it is trigger, end-of-interrupt or inject.

The queue descriptors live in a store outside the block, which has an asynchronous read port. On every request the block does the following:
- It drives the queue index to the store.
- It takes back the descriptor's valid flag and both P/Q pairs, and picks one pair by the page parity.
- It computes the new pair, and writes it back in the same cycle, but only if the value changes.

One cycle after the request it presents a response: a valid flag, an error flag and load data. For stores that must be forwarded, it also presents a one-cycle notify pulse, tagged with the queue index and page kind. Routing that pulse onward is done elsewhere.

P/Q encoding in this block: bit 1 is P and bit 0 is Q.

Top module: `esb_page_ctrl`

## Requirements
- R1: The queue index is `addr >> (PAGE_SHIFT+1)` and appears on `desc_idx_o` in the request cycle. Address bit `PAGE_SHIFT` = 0 selects the notification pair and 1 selects the escalation pair.
- R2: Every request produces `rsp_valid_o` exactly one cycle later, with `rsp_err_o`, `rsp_rdata_o` and `notify_o` valid in that same cycle. Reset clears `rsp_valid_o` and `notify_o`. `notify_o` is raised only for accepted stores.
- R3: A load at offset 0x000–0x7FF is an EOI. If Q was 1, the pair becomes 10 and the load returns 1. If Q was 0, the pair becomes 00 and the load returns 0.
- R4: A load at offset 0x800–0xBFF returns the current pair in data bits [1:0] and leaves it unchanged.
- R5: A load at offset 0xC00–0xFFF sets the pair to offset bits [9:8] and returns the previous pair in bits [1:0].
- R6: A store at offset 0x000–0x3FF is a trigger. The transitions are 00→10 with notify, 10→11, 11→11 and 01→01, and only the first one notifies.
- R7: A store at offset 0x400–0x7FF is an EOI with the transform of R3, and it notifies when Q was 1.
- R8: A store at offset 0x800–0xBFF on a notification page notifies and leaves the pair unchanged. On an escalation page it is an error with no notify.
- R9: A store at offset 0xC00–0xFFF is an error. It causes no write-back and no notify.
- R10: If the descriptor is invalid, every access is an error with no write-back and no notify. An erroring load returns all ones, and any store returns zero data.
- R11: The selected pair is written back only when its new value differs from the old one. An error never writes.
- R12: Address bits from 12 up to `PAGE_SHIFT-1` have no effect on the operation or on the page selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address within the page window |
| desc_idx_o | output | IDX_W | Queue index sent to the descriptor store |
| desc_valid_i | input | 1 | Descriptor valid flag for `desc_idx_o` |
| desc_note_pq_i | input | 2 | Notification P/Q of the descriptor |
| desc_esc_pq_i | input | 2 | Escalation P/Q of the descriptor |
| desc_we_o | output | 1 | Write-back enable, same cycle as the request |
| desc_wr_esc_o | output | 1 | Write-back target: 1 = escalation pair |
| desc_wr_pq_o | output | 2 | Write-back P/Q value |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Response error flag |
| rsp_rdata_o | output | DATA_W | Load data |
| notify_o | output | 1 | Notify pulse |
| notify_idx_o | output | IDX_W | Queue index of the notify |
| notify_esc_o | output | 1 | Notify came from an escalation page |

## Verification
The block holds no P/Q state. The only state it has is its response register, so any fault in the decode or in the P/Q transform shows at the ports within one cycle. A wrong pair or a write-back on an unchanged value shows on `desc_we_o` in the request cycle. A wrong load value, notify or error flag shows on the response in the following cycle. Back-to-back requests to the same queue check that each request sees the previous request's write-back. Requests with the middle address bits set check that those bits cannot change the operation or the page kind.

// File: rtl/esb_pkg.sv
package esb_pkg;

  typedef enum logic [2:0] {
    OP_LD_EOI,
    OP_LD_GET,
    OP_LD_SET,
    OP_ST_TRIG,
    OP_ST_EOI,
    OP_ST_INJ,
    OP_ST_BAD
  } esb_op_e;

  localparam int unsigned OFF_W = 12;

  typedef struct packed {
    logic       ntf;
    logic [1:0] pq;
  } pq_res_t;

  // P = bit 1, Q = bit 0
  function automatic pq_res_t pq_trigger(logic [1:0] pq);
    pq_res_t r;
    unique case (pq)
      2'b00:   r = '{ntf: 1'b1, pq: 2'b10};
      2'b01:   r = '{ntf: 1'b0, pq: 2'b01};
      default: r = '{ntf: 1'b0, pq: 2'b11};
    endcase
    return r;
  endfunction

  function automatic pq_res_t pq_eoi(logic [1:0] pq);
    pq_res_t r;
    if (pq[0]) r = '{ntf: 1'b1, pq: 2'b10};
    else       r = '{ntf: 1'b0, pq: 2'b00};
    return r;
  endfunction

endpackage

// File: rtl/esb_page_decode.sv
module esb_page_decode
  import esb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_SHIFT = 16,
  localparam int unsigned IDX_W     = ADDR_W - PAGE_SHIFT - 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              esc_o,
  output esb_op_e           op_o,
  output logic [1:0]        set_val_o
);

  logic [OFF_W-1:0] off;

  assign off       = addr_i[OFF_W-1:0];
  assign idx_o     = addr_i[ADDR_W-1:PAGE_SHIFT+1];
  assign esc_o     = addr_i[PAGE_SHIFT];
  assign set_val_o = off[9:8];

  // bits between the 4 KB offset and the page bit carry no meaning
  generate
    if (PAGE_SHIFT > OFF_W) begin : g_mid
      logic unused_mid;
      assign unused_mid = ^addr_i[PAGE_SHIFT-1:OFF_W];
    end
  endgenerate

  logic unused_off;
  assign unused_off = ^off[7:0];

  always_comb begin
    if (!write_i) begin
      unique case (off[11:10])
        2'b00, 2'b01: op_o = OP_LD_EOI;
        2'b10:        op_o = OP_LD_GET;
        default:      op_o = OP_LD_SET;
      endcase
    end else begin
      unique case (off[11:10])
        2'b00:   op_o = OP_ST_TRIG;
        2'b01:   op_o = OP_ST_EOI;
        2'b10:   op_o = OP_ST_INJ;
        default: op_o = OP_ST_BAD;
      endcase
    end
  end

endmodule

// File: rtl/esb_pq_engine.sv
module esb_pq_engine
  import esb_pkg::*;
(
  input  esb_op_e    op_i,
  input  logic       esc_i,
  input  logic [1:0] set_val_i,
  input  logic [1:0] cur_pq_i,
  output logic [1:0] new_pq_o,
  output logic [1:0] ld_val_o,
  output logic       ntf_o,
  output logic       err_o
);

  pq_res_t trig_r, eoi_r;

  assign trig_r = pq_trigger(cur_pq_i);
  assign eoi_r  = pq_eoi(cur_pq_i);

  always_comb begin
    new_pq_o = cur_pq_i;
    ld_val_o = 2'b00;
    ntf_o    = 1'b0;
    err_o    = 1'b0;
    unique case (op_i)
      OP_LD_EOI: begin
        new_pq_o = eoi_r.pq;
        ld_val_o = {1'b0, eoi_r.ntf};
      end
      OP_LD_GET: ld_val_o = cur_pq_i;
      OP_LD_SET: begin
        new_pq_o = set_val_i;
        ld_val_o = cur_pq_i;
      end
      OP_ST_TRIG: begin
        new_pq_o = trig_r.pq;
        ntf_o    = trig_r.ntf;
      end
      OP_ST_EOI: begin
        new_pq_o = eoi_r.pq;
        ntf_o    = eoi_r.ntf;
      end
      OP_ST_INJ: begin
        // inject is meaningless on the escalation pair
        err_o = esc_i;
        ntf_o = !esc_i;
      end
      default: err_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/esb_page_ctrl.sv
module esb_page_ctrl
  import esb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_SHIFT = 16,
  parameter int unsigned DATA_W     = 64,
  localparam int unsigned IDX_W     = ADDR_W - PAGE_SHIFT - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [IDX_W-1:0]  desc_idx_o,
  input  logic              desc_valid_i,
  input  logic [1:0]        desc_note_pq_i,
  input  logic [1:0]        desc_esc_pq_i,
  output logic              desc_we_o,
  output logic              desc_wr_esc_o,
  output logic [1:0]        desc_wr_pq_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              notify_o,
  output logic [IDX_W-1:0]  notify_idx_o,
  output logic              notify_esc_o
);

  esb_op_e     op;
  logic        esc;
  logic [1:0]  set_val;
  logic [1:0]  cur_pq, new_pq, ld_val;
  logic        eng_ntf, eng_err, err;
  logic [DATA_W-1:0] rdata_d;

  esb_page_decode #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_dec (
    .addr_i    (req_addr_i),
    .write_i   (req_write_i),
    .idx_o     (desc_idx_o),
    .esc_o     (esc),
    .op_o      (op),
    .set_val_o (set_val)
  );

  assign cur_pq = esc ? desc_esc_pq_i : desc_note_pq_i;

  esb_pq_engine u_eng (
    .op_i      (op),
    .esc_i     (esc),
    .set_val_i (set_val),
    .cur_pq_i  (cur_pq),
    .new_pq_o  (new_pq),
    .ld_val_o  (ld_val),
    .ntf_o     (eng_ntf),
    .err_o     (eng_err)
  );

  assign err           = eng_err || !desc_valid_i;
  assign desc_we_o     = req_valid_i && !err && (new_pq != cur_pq);
  assign desc_wr_esc_o = esc;
  assign desc_wr_pq_o  = new_pq;

  always_comb begin
    rdata_d = '0;
    if (!req_write_i) begin
      if (err) rdata_d = '1;
      else     rdata_d[1:0] = ld_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_err_o    <= 1'b0;
      rsp_rdata_o  <= '0;
      notify_o     <= 1'b0;
      notify_idx_o <= '0;
      notify_esc_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      notify_o    <= req_valid_i && !err && eng_ntf;
      if (req_valid_i) begin
        rsp_err_o    <= err;
        rsp_rdata_o  <= rdata_d;
        notify_idx_o <= desc_idx_o;
        notify_esc_o <= esc;
      end
    end
  end

endmodule

// File: rtl/esb_page_ctrl_chk.sv
module esb_page_ctrl_chk #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_SHIFT = 16,
  parameter int unsigned DATA_W     = 64,
  localparam int unsigned IDX_W     = ADDR_W - PAGE_SHIFT - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              desc_valid_i,
  input logic [1:0]        desc_note_pq_i,
  input logic [1:0]        desc_esc_pq_i,
  input logic              desc_we_o,
  input logic              desc_wr_esc_o,
  input logic [1:0]        desc_wr_pq_o,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              notify_o
);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i)); // R2

  AST_NOTIFY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> rsp_valid_o && !rsp_err_o); // R2

  AST_WB_CHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_we_o |-> desc_wr_pq_o != (desc_wr_esc_o ? desc_esc_pq_i : desc_note_pq_i)); // R11

  AST_NO_WB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !desc_we_o); // R11

  AST_INVALID_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !desc_valid_i |-> !desc_we_o); // R10

  AST_INVALID_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !desc_valid_i |=> rsp_err_o && !notify_o); // R10

  AST_ERR_LOAD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && !desc_valid_i |=> &rsp_rdata_o); // R10

  AST_GET_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && req_addr_i[11:10] == 2'b10 |-> !desc_we_o); // R4

  AST_ESC_INJECT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i && req_addr_i[PAGE_SHIFT] && req_addr_i[11:10] == 2'b10
    |=> rsp_err_o && !notify_o); // R8

  AST_HIGH_STORE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i && req_addr_i[11:10] == 2'b11 |-> !desc_we_o); // R9

  AST_LOAD_NO_NOTIFY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i |=> !notify_o); // R2

endmodule

bind esb_page_ctrl esb_page_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_SHIFT (PAGE_SHIFT),
  .DATA_W     (DATA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_write_i    (req_write_i),
  .req_addr_i     (req_addr_i),
  .desc_valid_i   (desc_valid_i),
  .desc_note_pq_i (desc_note_pq_i),
  .desc_esc_pq_i  (desc_esc_pq_i),
  .desc_we_o      (desc_we_o),
  .desc_wr_esc_o  (desc_wr_esc_o),
  .desc_wr_pq_o   (desc_wr_pq_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_err_o      (rsp_err_o),
  .rsp_rdata_o    (rsp_rdata_o),
  .notify_o       (notify_o)
);

// File: tb/sim_esb_page_ctrl.sv
`timescale 1ns/1ps
module sim_esb_page_ctrl;

  localparam int unsigned ADDR_W = 24;
  localparam int unsigned SHIFT  = 16;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned IDX_W  = ADDR_W - SHIFT - 1;
  localparam int unsigned NQ     = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [IDX_W-1:0]  desc_idx;
  logic              desc_valid;
  logic [1:0]        note_pq, esc_pq;
  logic              desc_we, desc_wr_esc;
  logic [1:0]        desc_wr_pq;
  logic              rsp_valid, rsp_err, notify, notify_esc;
  logic [DATA_W-1:0] rsp_rdata;
  logic [IDX_W-1:0]  notify_idx;

  logic [1:0] m_note [NQ];
  logic [1:0] m_esc  [NQ];
  logic       m_vld  [NQ];
  int         wr_cnt;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  esb_page_ctrl #(.ADDR_W(ADDR_W), .PAGE_SHIFT(SHIFT), .DATA_W(DATA_W)) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_write_i    (req_write),
    .req_addr_i     (req_addr),
    .desc_idx_o     (desc_idx),
    .desc_valid_i   (desc_valid),
    .desc_note_pq_i (note_pq),
    .desc_esc_pq_i  (esc_pq),
    .desc_we_o      (desc_we),
    .desc_wr_esc_o  (desc_wr_esc),
    .desc_wr_pq_o   (desc_wr_pq),
    .rsp_valid_o    (rsp_valid),
    .rsp_err_o      (rsp_err),
    .rsp_rdata_o    (rsp_rdata),
    .notify_o       (notify),
    .notify_idx_o   (notify_idx),
    .notify_esc_o   (notify_esc)
  );

  assign desc_valid = m_vld[desc_idx];
  assign note_pq    = m_note[desc_idx];
  assign esc_pq     = m_esc[desc_idx];

  always @(posedge clk) begin
    if (desc_we) begin
      wr_cnt <= wr_cnt + 1;
      if (desc_wr_esc) m_esc[desc_idx] <= desc_wr_pq;
      else             m_note[desc_idx] <= desc_wr_pq;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(int idx, bit esc, logic [11:0] off);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[ADDR_W-1:SHIFT+1] = IDX_W'(idx);
    a[SHIFT] = esc;
    a[11:0] = off;
    return a;
  endfunction

  // [29] wr [28] esc [27:21] idx [20:9] off [8:7] init [6] vld
  // [5] err [4:3] load data [2] notify [1:0] pair after access
  localparam int NV = 23;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0,1'b0,7'd3,  12'h000,2'b11,1'b1, 1'b0,2'd1,1'b0,2'b10}, // R3
    {1'b0,1'b0,7'd4,  12'h7F8,2'b10,1'b1, 1'b0,2'd0,1'b0,2'b00}, // R3
    {1'b0,1'b0,7'd5,  12'h400,2'b01,1'b1, 1'b0,2'd1,1'b0,2'b10}, // R3
    {1'b0,1'b1,7'd6,  12'h000,2'b00,1'b1, 1'b0,2'd0,1'b0,2'b00}, // R3
    {1'b0,1'b0,7'd7,  12'h800,2'b01,1'b1, 1'b0,2'd1,1'b0,2'b01}, // R4
    {1'b0,1'b1,7'd8,  12'hBFF,2'b11,1'b1, 1'b0,2'd3,1'b0,2'b11}, // R4
    {1'b0,1'b0,7'd9,  12'hC00,2'b11,1'b1, 1'b0,2'd3,1'b0,2'b00}, // R5
    {1'b0,1'b0,7'd10, 12'hD10,2'b00,1'b1, 1'b0,2'd0,1'b0,2'b01}, // R5
    {1'b0,1'b1,7'd11, 12'hE00,2'b01,1'b1, 1'b0,2'd1,1'b0,2'b10}, // R5
    {1'b0,1'b0,7'd12, 12'hFFF,2'b11,1'b1, 1'b0,2'd3,1'b0,2'b11}, // R5
    {1'b1,1'b0,7'd13, 12'h000,2'b00,1'b1, 1'b0,2'd0,1'b1,2'b10}, // R6
    {1'b1,1'b0,7'd14, 12'h3FF,2'b10,1'b1, 1'b0,2'd0,1'b0,2'b11}, // R6
    {1'b1,1'b1,7'd15, 12'h100,2'b11,1'b1, 1'b0,2'd0,1'b0,2'b11}, // R6
    {1'b1,1'b0,7'd16, 12'h000,2'b01,1'b1, 1'b0,2'd0,1'b0,2'b01}, // R6
    {1'b1,1'b0,7'd17, 12'h400,2'b11,1'b1, 1'b0,2'd0,1'b1,2'b10}, // R7
    {1'b1,1'b1,7'd18, 12'h7FF,2'b10,1'b1, 1'b0,2'd0,1'b0,2'b00}, // R7
    {1'b1,1'b0,7'd19, 12'h500,2'b01,1'b1, 1'b0,2'd0,1'b1,2'b10}, // R7
    {1'b1,1'b0,7'd20, 12'h800,2'b00,1'b1, 1'b0,2'd0,1'b1,2'b00}, // R8
    {1'b1,1'b1,7'd21, 12'h900,2'b10,1'b1, 1'b1,2'd0,1'b0,2'b10}, // R8
    {1'b1,1'b0,7'd22, 12'hC00,2'b00,1'b1, 1'b1,2'd0,1'b0,2'b00}, // R9
    {1'b0,1'b0,7'd23, 12'h800,2'b10,1'b0, 1'b1,2'd0,1'b0,2'b10}, // R10
    {1'b1,1'b0,7'd24, 12'h000,2'b00,1'b0, 1'b1,2'd0,1'b0,2'b00}, // R10
    {1'b0,1'b0,7'd127,12'hE00,2'b00,1'b1, 1'b0,2'd0,1'b0,2'b10}  // R5
  };

  function automatic string tag_of(bit wr, logic [11:0] off, bit vld);
    if (!vld) return "R10";
    if (!wr) return off < 12'h800 ? "R3" : (off < 12'hC00 ? "R4" : "R5");
    if (off < 12'h400) return "R6";
    if (off < 12'h800) return "R7";
    if (off < 12'hC00) return "R8";
    return "R9";
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NQ; i++) begin
      m_note[i] = 2'b00;
      m_esc[i]  = 2'b00;
      m_vld[i]  = 1'b1;
    end
    wr_cnt = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 reset rsp_valid", 64'(rsp_valid), 0);
    chk(notify === 1'b0, "R2 reset notify", 64'(notify), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin : vec_loop
      logic [29:0] t;
      bit wr, esc, vld, e_err, e_ntf;
      int idx;
      logic [11:0] off;
      logic [1:0] init, e_dat, e_pq, got_pq;
      string tg;
      t = VEC[v];
      wr = t[29]; esc = t[28]; idx = int'(t[27:21]); off = t[20:9];
      init = t[8:7]; vld = t[6]; e_err = t[5]; e_dat = t[4:3]; e_ntf = t[2]; e_pq = t[1:0];
      tg = tag_of(wr, off, vld);
      if (esc) begin m_esc[idx] = init; m_note[idx] = ~init; end
      else     begin m_note[idx] = init; m_esc[idx] = ~init; end
      m_vld[idx] = vld;
      wr_cnt = 0;
      req_valid = 1'b1; req_write = wr; req_addr = mk_addr(idx, esc, off);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid === 1'b1, tg, 64'(rsp_valid), 1);
      chk(rsp_err === e_err, tg, 64'(rsp_err), 64'(e_err));
      if (!wr && e_err)
        chk(rsp_rdata === '1, tg, rsp_rdata, '1);
      else if (!wr)
        chk(rsp_rdata === 64'(e_dat), tg, rsp_rdata, 64'(e_dat));
      else
        chk(rsp_rdata === '0, tg, rsp_rdata, 0);
      chk(notify === e_ntf, {tg, " R2 notify"}, 64'(notify), 64'(e_ntf));
      if (e_ntf) begin
        chk(notify_idx === IDX_W'(idx), {tg, " R2 notify idx"}, 64'(notify_idx), 64'(idx));
        chk(notify_esc === esc, {tg, " R2 notify page"}, 64'(notify_esc), 64'(esc));
      end
      got_pq = esc ? m_esc[idx] : m_note[idx];
      chk(got_pq === e_pq, {tg, " R1 pair"}, 64'(got_pq), 64'(e_pq));
      chk((esc ? m_note[idx] : m_esc[idx]) === ~init, {tg, " R1 other pair"},
          64'(esc ? m_note[idx] : m_esc[idx]), 64'(~init));
      chk(wr_cnt == ((e_pq != init && !e_err) ? 1 : 0), {tg, " R11 writes"},
          64'(wr_cnt), 64'((e_pq != init && !e_err) ? 1 : 0));
      m_vld[idx] = 1'b1;
    end

    // R1: index visible in request cycle
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk_addr(85, 1'b1, 12'h800);
    #1;
    chk(desc_idx === IDX_W'(85), "R1 desc_idx", 64'(desc_idx), 85);
    @(negedge clk);
    req_valid = 1'b0;

    // R12: middle bits set, escalation page get
    m_note[30] = 2'b10; m_esc[30] = 2'b01;
    req_valid = 1'b1; req_write = 1'b0;
    req_addr = mk_addr(30, 1'b1, 12'h800) | ADDR_W'(24'h00F000);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_rdata === 64'h1, "R12 esc get", rsp_rdata, 1);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = mk_addr(31, 1'b0, 12'h000) | ADDR_W'(24'h00F000);
    m_note[31] = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    chk(notify === 1'b1 && m_note[31] === 2'b10, "R12 trigger", 64'(m_note[31]), 2);

    // R6 back-to-back triggers on one queue
    m_note[40] = 2'b00;
    req_valid = 1'b1; req_write = 1'b1; req_addr = mk_addr(40, 1'b0, 12'h010);
    @(negedge clk);
    chk(notify === 1'b1, "R6 first trigger", 64'(notify), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(notify === 1'b0, "R6 second trigger", 64'(notify), 0);
    chk(m_note[40] === 2'b11, "R6 pair after two", 64'(m_note[40]), 3);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 idle", 64'(rsp_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule